// File: doc/BRIEF.md
# Cascadable presettable binary counter

A synchronous up-counter, four bits wide by default, with a parallel preset and two count enables. The first enable only gates counting. The second enable gates counting and also qualifies the terminal-count flag, so that several stages can be chained into one wide synchronous counter. In a chain, each stage's terminal-count output drives the second enable of the next stage up. All stages share one clock.

Four modes apply in fixed precedence, highest first: clear, preset load, increment, hold. A build-time parameter selects how the clear behaves. In the asynchronous setting, a low reset empties the state at once. In the synchronous setting, the clear takes effect on the next rising edge, like any other mode. Every other state change happens on the rising clock edge.

Top module: `presettable_cnt`

## Requirements
- R1: The state counts modulo 2^WIDTH. When the state is all ones and a count is enabled, the next rising edge gives zero; with WIDTH=4, 15 becomes 0.
- R2: With ASYNC_RESET=1, a low rst_ni forces q_o to zero without waiting for a clock edge. While rst_ni stays low, q_o remains zero whatever load_ni, en_count_i and en_chain_i do.
- R3: With ASYNC_RESET=0, q_o keeps its value while rst_ni is low between edges. A rising edge with rst_ni low clears q_o, even when a load or a count is requested at the same edge.
- R4: When load_ni is low and rst_ni is high at a rising edge, q_o takes the value of data_i, whatever the levels of en_count_i and en_chain_i.
- R5: When rst_ni, load_ni, en_count_i and en_chain_i are all high at a rising edge, q_o increases by one.
- R6: When load_ni and rst_ni are high at a rising edge and either en_count_i or en_chain_i is low, q_o keeps its value.
- R7: tc_o is high exactly when q_o is all ones and en_chain_i is high. It follows en_chain_i within the same cycle and ignores en_count_i and load_ni.
- R8: Two stages, with the lower tc_o driving the upper en_chain_i and the upper stage reading out the high nibble, count through 0 to 255 and then wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state changes on its rising edge |
| rst_ni | input | 1 | Active-low clear, asynchronous or synchronous according to ASYNC_RESET |
| load_ni | input | 1 | Active-low parallel preset enable |
| en_count_i | input | 1 | Count enable that gates counting only |
| en_chain_i | input | 1 | Count enable that gates counting and qualifies tc_o |
| data_i | input | WIDTH | Preset value |
| q_o | output | WIDTH | Counter state |
| tc_o | output | 1 | Terminal count: state all ones and en_chain_i high |

## Verification
The following rules are checked on every clock edge after reset: single-step increment, modulo wrap, the effect of a preset, hold when either enable is low, the terminal-count equation, and a zero state on the first edge after the clear is released. Other behaviours can only be shown by the bench's scenarios. One is the timing of the clear relative to the edge: immediate in one variant, deferred to the edge in the other, with the deferred clear overriding a preset. Another is that tc_o responds to en_chain_i between edges. The last is the carry behaviour of a two-stage chain through a full 256-state cycle. A randomised sweep compares both clear variants against an arithmetic model of the precedence rules.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_INC  = 2'd1,
    MODE_LOAD = 2'd2,
    MODE_CLR  = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             en_count_i,
  input  logic             en_chain_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  cnt_mode_e mode;

  // precedence: clear > load > count > hold
  always_comb begin
    if (!rst_ni)                      mode = MODE_CLR;
    else if (!load_ni)                mode = MODE_LOAD;
    else if (en_count_i && en_chain_i) mode = MODE_INC;
    else                              mode = MODE_HOLD;
  end

  always_comb begin
    unique case (mode)
      MODE_CLR:  nxt_o = '0;
      MODE_LOAD: nxt_o = data_i;
      MODE_INC:  nxt_o = q_i + ONE;
      default:   nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             en_chain_i,
  output logic             tc_o
);
  assign tc_o = (&q_i) & en_chain_i;
endmodule

// File: rtl/presettable_cnt.sv
module presettable_cnt #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             en_count_i,
  input  logic             en_chain_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o,
  output logic             tc_o
);
  logic [WIDTH-1:0] nxt;

  cnt_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .rst_ni     (rst_ni),
    .load_ni    (load_ni),
    .en_count_i (en_count_i),
    .en_chain_i (en_chain_i),
    .data_i     (data_i),
    .q_i        (q_o),
    .nxt_o      (nxt)
  );

  cnt_state_reg #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt),
    .q_o    (q_o)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .q_i        (q_o),
    .en_chain_i (en_chain_i),
    .tc_o       (tc_o)
  );
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic             en_count_i,
  input logic             en_chain_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] q_o,
  input logic             tc_o
);
  logic cnt_go;
  assign cnt_go = load_ni && en_count_i && en_chain_i;

  // R5
  a_r5_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_go |=> (q_o == WIDTH'($past(q_o) + 1'b1)));

  // R1
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_go && (&q_o)) |=> (q_o == '0));

  // R4
  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (q_o == $past(data_i)));

  // R6
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(en_count_i && en_chain_i)) |=> $stable(q_o));

  // R7
  a_r7_tc_needs_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (en_chain_i && (&q_o)));

  a_r7_tc_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_chain_i && (&q_o)) |-> tc_o);

  // R2 and R3: state is zero on the first edge after the clear is released
  generate
    if (ASYNC_RESET) begin : g_chk_async
      a_r2_clear_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (q_o == '0));
    end else begin : g_chk_sync
      a_r3_clear_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (q_o == '0));
    end
  endgenerate
endmodule

bind presettable_cnt cnt_checker #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_ni    (load_ni),
  .en_count_i (en_count_i),
  .en_chain_i (en_chain_i),
  .data_i     (data_i),
  .q_o        (q_o),
  .tc_o       (tc_o)
);

// File: tb/sim_presettable_cnt.sv
`timescale 1ns/1ps
module sim_presettable_cnt;
  logic       clk_i = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic       en_cnt = 1'b0;
  logic       en_chn = 1'b0;
  logic [3:0] data = 4'h0;
  logic [3:0] q0, q1, q_lo, q_hi;
  logic       tc0, tc1, tc_lo, tc_hi;
  logic       en_c = 1'b0;
  logic [3:0] m;
  int         checks = 0;
  int         errors = 0;

  always #4 clk_i = ~clk_i;

  presettable_cnt #(.WIDTH(4), .ASYNC_RESET(1'b1)) u0 (
    .clk_i(clk_i), .rst_ni(rst_n), .load_ni(load_n), .en_count_i(en_cnt),
    .en_chain_i(en_chn), .data_i(data), .q_o(q0), .tc_o(tc0));

  presettable_cnt #(.WIDTH(4), .ASYNC_RESET(1'b0)) u1 (
    .clk_i(clk_i), .rst_ni(rst_n), .load_ni(load_n), .en_count_i(en_cnt),
    .en_chain_i(en_chn), .data_i(data), .q_o(q1), .tc_o(tc1));

  presettable_cnt #(.WIDTH(4), .ASYNC_RESET(1'b0)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_n), .load_ni(1'b1), .en_count_i(en_c),
    .en_chain_i(en_c), .data_i(4'h0), .q_o(q_lo), .tc_o(tc_lo));

  presettable_cnt #(.WIDTH(4), .ASYNC_RESET(1'b0)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_n), .load_ni(1'b1), .en_count_i(en_c),
    .en_chain_i(tc_lo), .data_i(4'h0), .q_o(q_hi), .tc_o(tc_hi));

  function automatic logic [3:0] ref_next(logic [3:0] q, logic r, logic ld,
                                          logic [3:0] d, logic ep, logic et);
    if (!r)           return 4'h0;
    else if (!ld)     return d;
    else if (ep && et) return q + 4'h1;
    else              return q;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    m = ref_next(m, rst_n, load_n, data, en_cnt, en_chn);
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m = 4'h0;
    repeat (3) @(negedge clk_i);
    // reset state
    chk("R2 reset q async", {4'h0, q0}, 8'h0);
    chk("R3 reset q sync", {4'h0, q1}, 8'h0);
    chk("R7 reset tc", {6'h0, tc0, tc1}, 8'h0);
    rst_n = 1'b1;
    tick();

    // R4: load regardless of enables
    for (int e = 0; e < 4; e++) begin
      load_n = 1'b0; data = 4'(3 + 5 * e); {en_cnt, en_chn} = 2'(e);
      tick();
      chk("R4 load async", {4'h0, q0}, {4'h0, m});
      chk("R4 load sync", {4'h0, q1}, {4'h0, m});
    end

    // R1: wrap 14 -> 15 -> 0
    load_n = 1'b0; data = 4'hE; tick();
    load_n = 1'b1; en_cnt = 1'b1; en_chn = 1'b1;
    tick(); chk("R5 inc to 15", {4'h0, q0}, 8'h0F);
    tick(); chk("R1 wrap async", {4'h0, q0}, 8'h00);
    chk("R1 wrap sync", {4'h0, q1}, 8'h00);

    // R6: hold with either enable low, then count
    load_n = 1'b0; data = 4'h7; tick(); load_n = 1'b1;
    en_cnt = 1'b0; en_chn = 1'b1; tick();
    chk("R6 hold en_count low", {4'h0, q0}, 8'h07);
    en_cnt = 1'b1; en_chn = 1'b0; tick();
    chk("R6 hold en_chain low", {4'h0, q1}, 8'h07);
    en_chn = 1'b1; tick();
    chk("R5 count both high", {q0, q1}, 8'h88);

    // R7: tc over every state and control combination, between edges
    for (int v = 0; v < 16; v++) begin
      load_n = 1'b0; data = 4'(v); en_cnt = 1'b0; en_chn = 1'b0; tick();
      for (int c = 0; c < 8; c++) begin
        {load_n, en_cnt, en_chn} = 3'(c);
        #0.3;
        chk("R7 tc async", {7'h0, tc0}, {7'h0, (v == 15) && en_chn});
        chk("R7 tc sync", {7'h0, tc1}, {7'h0, (v == 15) && en_chn});
      end
      load_n = 1'b1; en_cnt = 1'b0; en_chn = 1'b0;
    end

    // R2 / R3: clear timing between edges
    load_n = 1'b0; data = 4'h9; tick();
    load_n = 1'b1; en_cnt = 1'b0; en_chn = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk("R2 async clear immediate", {4'h0, q0}, 8'h00);
    chk("R3 sync clear waits for edge", {4'h0, q1}, 8'h09);
    load_n = 1'b0; data = 4'h5; en_cnt = 1'b1; en_chn = 1'b1;
    #1;
    chk("R2 async clear ignores load", {4'h0, q0}, 8'h00);
    m = 4'h9;
    tick();
    chk("R3 sync clear overrides load", {4'h0, q1}, 8'h00);
    chk("R2 async held low", {4'h0, q0}, 8'h00);
    rst_n = 1'b1; load_n = 1'b1; en_cnt = 1'b0; en_chn = 1'b0;
    tick();

    // randomised sweep against the precedence model
    void'($urandom(32'd17));
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom;
      rst_n  = (r[3:0] != 4'h0);
      load_n = (r[5:4] != 2'b00);
      en_cnt = (r[7:6] != 2'b00);
      en_chn = (r[9:8] != 2'b00);
      data   = r[13:10];
      tick();
      chk("R4 R5 R6 sweep async", {4'h0, q0}, {4'h0, m});
      chk("R3 sweep sync", {4'h0, q1}, {4'h0, m});
      chk("R7 sweep tc", {6'h0, tc0, tc1}, {6'h0, {2{(m == 4'hF) && en_chn}}});
    end
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();

    // R8: two-stage chain through all 256 states
    chk("R8 chain start", {q_hi, q_lo}, 8'h00);
    en_c = 1'b1;
    for (int i = 1; i <= 256; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R8 chain count", {q_hi, q_lo}, 8'(i));
      if (i == 255) chk("R8 chain carry out", {7'h0, tc_hi}, 8'h01);
    end
    en_c = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule